// File: doc/BRIEF.md
# Single-Channel Fly-By DMA Controller

This block copies a block of bytes between one I/O device and memory so that the processor does not move the data itself. Software loads a start address, a byte count and a control word through a narrow write-only configuration port. When the armed channel sees the device raise its service request, it asks the processor for the bus. Once the processor grants the bus, the channel acknowledges the device and issues one memory-port strobe per byte. On each strobe the address steps up and the remaining count steps down.

The transfer is fly-by. The device places data on the shared bus, or takes it from there, in the cycle of each strobe, so the controller itself carries no data. A two-bit field in the control word picks how the bus is shared. Burst keeps the bus for the whole block. Cycle stealing hands the bus back after every byte. Idle-only moves a byte only in a cycle where the processor reports that it is not using the bus. When the count runs out, the controller releases the bus and raises a sticky interrupt. A later write to the control word clears that interrupt.

Top module: `dmx_channel`

## Requirements
- R1: After reset, bus_req, dev_ack, mem_valid and irq are all low, and the channel is idle.
- R2: A configuration write uses select 0 for the start address, select 1 for the byte count and select 2 for the control word. The control word has bit 0 for direction (1 = device to memory, which drives mem_we high), bits 2:1 for the sharing mode and bit 3 as the go flag. mem_addr shows the address register and mem_we shows the direction bit. Writes are ignored while the channel is armed or holds the bus. A control write without go leaves the channel idle, and it then ignores device requests.
- R3: An armed channel with a non-zero count raises bus_req in the cycle after it samples dev_req high. It never strobes memory unless bus_grant is high in that same cycle.
- R4: dev_ack is high exactly in the cycles where bus_req and bus_grant are both high.
- R5: Each byte takes one cycle of mem_valid. On it the address increases by one (wrapping at the address width) and the count decreases by one.
- R6: In burst mode (code 0; code 3 behaves the same), bus_req stays high from the first request until the last byte, including cycles where dev_req is low.
- R7: In cycle-stealing mode (code 1), bus_req falls in the cycle after each byte and is raised again once dev_req is sampled high.
- R8: In idle-only mode (code 2), mem_valid is high only in cycles where cpu_idle is high.
- R9: In the cycle after the last byte, bus_req is low and irq is high. Arming with a count of zero raises irq two cycles after the control write, with no bus request and no strobe.
- R10: irq stays high until a control-word write. Address and count writes leave it set.
- R11: While bus_grant is low, no byte is moved and the address holds. The same byte is retried once grant returns.
- R12: In cycle-stealing and idle-only modes, a dev_req that is low while the bus is held drops bus_req in the next cycle. The transfer resumes from the same address when dev_req returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| cfg_wdata | input | REG_W | Configuration write data |
| dev_req | input | 1 | Device service request |
| dev_ack | output | 1 | Acknowledge to the device while the bus is owned |
| bus_req | output | 1 | Bus request to the processor |
| bus_grant | input | 1 | Bus grant from the processor |
| cpu_idle | input | 1 | Processor reports that the bus is unused this cycle |
| mem_valid | output | 1 | Memory-port strobe, one per byte |
| mem_we | output | 1 | Memory-port write enable (direction) |
| mem_addr | output | ADDR_W | Memory-port byte address |
| irq | output | 1 | Completion interrupt, sticky |

## Verification
The checker assumes that the processor side behaves sensibly. Grant may arrive or disappear at any cycle, but configuration writes reach the channel only through cfg_we, and the mode cannot change while bus_req is high. The bench produces grant from bus_req with a one-cycle delay, gated by an enable that tests pull low to take the bus away in the middle of a block. All inputs change just after a rising edge, and dev_req and cpu_idle are toggled in patterns that exercise pauses, grant loss and idle gaps in every mode.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

   typedef enum logic [1:0] {
      SH_BURST    = 2'd0,
      SH_STEAL    = 2'd1,
      SH_IDLEONLY = 2'd2,
      SH_RSVD     = 2'd3
   } share_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_BUS   = 2'd2,
      ST_DONE  = 2'd3
   } seq_e;

   localparam logic [1:0] SEL_ADDR = 2'd0;
   localparam logic [1:0] SEL_CNT  = 2'd1;
   localparam logic [1:0] SEL_CTL  = 2'd2;

   localparam int unsigned CTL_DIR  = 0;
   localparam int unsigned CTL_MODE = 1;
   localparam int unsigned CTL_GO   = 3;
   localparam int unsigned CTL_BITS = 4;

   // modes that keep the bus across a paused device request
   function automatic logic holds_bus(share_e m);
      return (m == SH_BURST) || (m == SH_RSVD);
   endfunction

endpackage

// File: rtl/dmx_regfile.sv
module dmx_regfile
   import dmx_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 12,
   parameter int REG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        sel,
   input  logic [REG_W-1:0]  wdata,
   input  logic              step,
   output logic [ADDR_W-1:0] addr_q,
   output logic              cnt_zero,
   output logic              cnt_last,
   output logic              dir_q,
   output share_e            mode_q,
   output logic              ctl_wr,
   output logic              ctl_go
);

   localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
   localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
         dir_q  <= 1'b0;
         mode_q <= SH_BURST;
      end else if (wr_en) begin
         case (sel)
            SEL_ADDR: addr_q <= wdata[ADDR_W-1:0];
            SEL_CNT:  cnt_q  <= wdata[CNT_W-1:0];
            SEL_CTL: begin
               dir_q  <= wdata[CTL_DIR];
               mode_q <= share_e'(wdata[CTL_MODE +: 2]);
            end
            default: ;
         endcase
      end else if (step) begin
         addr_q <= addr_q + ADDR_ONE;
         cnt_q  <= cnt_q - CNT_ONE;
      end
   end

   assign cnt_zero = (cnt_q == '0);
   assign cnt_last = (cnt_q == CNT_ONE);
   assign ctl_wr   = wr_en && (sel == SEL_CTL);
   assign ctl_go   = wdata[CTL_GO];

endmodule

// File: rtl/dmx_seq.sv
module dmx_seq
   import dmx_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   ctl_wr,
   input  logic   ctl_go,
   input  logic   cnt_zero,
   input  logic   cnt_last,
   input  logic   dev_req,
   input  logic   strobe,
   input  share_e mode,
   output seq_e   state,
   output logic   active
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
      end else begin
         case (state)
            ST_IDLE, ST_DONE: begin
               if (ctl_wr) state <= ctl_go ? ST_ARMED : ST_IDLE;
            end
            ST_ARMED: begin
               if (cnt_zero)     state <= ST_DONE;
               else if (dev_req) state <= ST_BUS;
            end
            ST_BUS: begin
               if (strobe) begin
                  if (cnt_last)              state <= ST_DONE;
                  else if (mode == SH_STEAL) state <= ST_ARMED;
               end else if (!dev_req && !holds_bus(mode)) begin
                  state <= ST_ARMED;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign active = (state == ST_ARMED) || (state == ST_BUS);

endmodule

// File: rtl/dmx_gate.sv
module dmx_gate
   import dmx_pkg::*;
(
   input  logic   in_bus,
   input  logic   bus_grant,
   input  logic   dev_req,
   input  logic   cpu_idle,
   input  share_e mode,
   output logic   own,
   output logic   strobe
);

   logic slot_ok;

   assign own     = in_bus && bus_grant;
   assign slot_ok = (mode != SH_IDLEONLY) || cpu_idle;
   assign strobe  = own && dev_req && slot_ok;

endmodule

// File: rtl/dmx_channel.sv
module dmx_channel
   import dmx_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 12,
   parameter int REG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [REG_W-1:0]  cfg_wdata,
   input  logic              dev_req,
   output logic              dev_ack,
   output logic              bus_req,
   input  logic              bus_grant,
   input  logic              cpu_idle,
   output logic              mem_valid,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              irq
);

   localparam int MIN_REG_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("dmx_channel: ADDR_W must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("dmx_channel: CNT_W must be at least 1");
      end
      if (REG_W < MIN_REG_W || REG_W < int'(CTL_BITS)) begin : g_bad_reg
         $error("dmx_channel: REG_W too narrow for address, count or control");
      end
   endgenerate

   seq_e   state;
   share_e mode_q;
   logic   active, wr_ok, step;
   logic   cnt_zero, cnt_last, dir_q, ctl_wr, ctl_go;
   logic   own;

   assign wr_ok = cfg_we && !active;

   dmx_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_ok),
      .sel      (cfg_sel),
      .wdata    (cfg_wdata),
      .step     (step),
      .addr_q   (mem_addr),
      .cnt_zero (cnt_zero),
      .cnt_last (cnt_last),
      .dir_q    (dir_q),
      .mode_q   (mode_q),
      .ctl_wr   (ctl_wr),
      .ctl_go   (ctl_go)
   );

   dmx_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (ctl_wr),
      .ctl_go   (ctl_go),
      .cnt_zero (cnt_zero),
      .cnt_last (cnt_last),
      .dev_req  (dev_req),
      .strobe   (step),
      .mode     (mode_q),
      .state    (state),
      .active   (active)
   );

   dmx_gate u_gate (
      .in_bus    (bus_req),
      .bus_grant (bus_grant),
      .dev_req   (dev_req),
      .cpu_idle  (cpu_idle),
      .mode      (mode_q),
      .own       (own),
      .strobe    (step)
   );

   assign bus_req   = (state == ST_BUS);
   assign irq       = (state == ST_DONE);
   assign dev_ack   = own;
   assign mem_valid = step;
   assign mem_we    = dir_q;

endmodule

// File: rtl/dmx_channel_chk.sv
module dmx_channel_chk
   import dmx_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic              bus_req,
   input logic              bus_grant,
   input logic              dev_ack,
   input logic              cpu_idle,
   input logic              mem_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              irq,
   input share_e            mode
);

   // R3
   strobe_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (bus_grant && bus_req));

   // R4
   ack_only_when_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |-> (bus_req && bus_grant));

   // R5
   addr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

   // R6
   burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !mem_valid && mode == SH_BURST) |=> bus_req);

   // R7
   steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mode == SH_STEAL) |=> !bus_req);

   // R8
   idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mode == SH_IDLEONLY) |-> cpu_idle);

   // R9
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!bus_req && !mem_valid));

   // R10
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !cfg_we) |=> irq);

   // R11
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !mem_valid) |=> $stable(mem_addr));

endmodule

bind dmx_channel dmx_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .bus_req   (bus_req),
   .bus_grant (bus_grant),
   .dev_ack   (dev_ack),
   .cpu_idle  (cpu_idle),
   .mem_valid (mem_valid),
   .mem_addr  (mem_addr),
   .irq       (irq),
   .mode      (mode_q)
);

// File: tb/dmx_channel_bench.sv
module dmx_channel_bench;

   localparam int ADDR_W = 16;
   localparam int CNT_W  = 12;
   localparam int REG_W  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [1:0]        cfg_sel = 2'd0;
   logic [REG_W-1:0]  cfg_wdata = '0;
   logic              dev_req = 1'b0;
   logic              bus_grant = 1'b0;
   logic              cpu_idle = 1'b0;
   logic              dev_ack, bus_req, mem_valid, mem_we, irq;
   logic [ADDR_W-1:0] mem_addr;

   logic  grant_en = 1'b1;
   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R1";

   // reference model state: 0 idle, 1 armed, 2 bus held, 3 done
   int m_st   = 0;
   int m_addr = 0;
   int m_cnt  = 0;
   int m_dir  = 0;
   int m_mode = 0;

   dmx_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_dmx_channel (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .dev_req(dev_req), .dev_ack(dev_ack),
      .bus_req(bus_req), .bus_grant(bus_grant), .cpu_idle(cpu_idle),
      .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .irq(irq)
   );

   always #10 clk = ~clk;

   // processor side: grant follows the request one cycle later
   always @(posedge clk) bus_grant <= grant_en & bus_req;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic bit m_strobe();
      return (m_st == 2) && bus_grant && dev_req && (m_mode != 2 || cpu_idle);
   endfunction

   // model update on each rising edge, from the requirements
   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_addr = 0; m_cnt = 0; m_dir = 0; m_mode = 0;
      end else if (m_st == 0 || m_st == 3) begin
         if (cfg_we) begin
            if (cfg_sel == 2'd0) m_addr = int'(cfg_wdata);
            if (cfg_sel == 2'd1) m_cnt = int'(cfg_wdata) % (1 << CNT_W);
            if (cfg_sel == 2'd2) begin
               m_dir  = int'(cfg_wdata[0]);
               m_mode = int'(cfg_wdata[2:1]);
               m_st   = cfg_wdata[3] ? 1 : 0;
            end
         end
      end else if (m_st == 1) begin
         if (m_cnt == 0) m_st = 3;
         else if (dev_req) m_st = 2;
      end else begin
         if (m_strobe()) begin
            m_addr = (m_addr + 1) % (1 << ADDR_W);
            m_cnt  = m_cnt - 1;
            if (m_cnt == 0) m_st = 3;
            else if (m_mode == 1) m_st = 1;
         end else if (!dev_req && (m_mode == 1 || m_mode == 2)) begin
            m_st = 1;
         end
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      chk(cur_req, "bus_req",   32'(bus_req),   32'(m_st == 2));
      chk(cur_req, "dev_ack",   32'(dev_ack),   32'((m_st == 2) && bus_grant));
      chk(cur_req, "mem_valid", 32'(mem_valid), 32'(m_strobe()));
      chk(cur_req, "mem_we",    32'(mem_we),    32'(m_dir));
      chk(cur_req, "mem_addr",  32'(mem_addr),  32'(m_addr));
      chk(cur_req, "irq",       32'(irq),       32'(m_st == 3));
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [REG_W-1:0] data);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      tick();
      cfg_we = 1'b0;
   endtask

   function automatic logic [REG_W-1:0] ctl(input bit go, input int mode, input bit dir);
      return REG_W'({go, 2'(mode), dir});
   endfunction

   task automatic wait_irq();
      for (int i = 0; i < 300; i++) begin
         if (irq) break;
         tick();
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired at %0t", $time);
      finish_run();
   end

   initial begin
      // R1: reset state
      cur_req = "R1";
      tick(); tick(); tick();
      chk("R1", "bus_req", 32'(bus_req), 0);
      chk("R1", "irq", 32'(irq), 0);
      rst_n = 1'b1;
      tick();

      // R2: programming, write ignored while armed
      cur_req = "R2";
      wr(2'd0, 16'h0010);
      wr(2'd1, 16'd4);
      wr(2'd2, ctl(1, 0, 1));
      wr(2'd0, 16'h0F00);
      tick();
      chk("R2", "mem_addr ignored write", 32'(mem_addr), 32'h10);
      chk("R2", "mem_we", 32'(mem_we), 1);

      // R3: request without grant
      cur_req = "R3";
      grant_en = 1'b0;
      dev_req = 1'b1;
      tick(); tick(); tick();
      chk("R3", "bus_req", 32'(bus_req), 1);
      chk("R3", "mem_valid", 32'(mem_valid), 0);

      // R4: grant arrives
      cur_req = "R4";
      grant_en = 1'b1;
      tick();
      chk("R4", "dev_ack", 32'(dev_ack), 1);
      chk("R5", "mem_valid", 32'(mem_valid), 1);

      // R6: device pause in burst keeps the bus
      cur_req = "R6";
      dev_req = 1'b0;
      tick(); tick();
      chk("R6", "bus_req", 32'(bus_req), 1);
      chk("R6", "mem_addr", 32'(mem_addr), 32'h10);
      dev_req = 1'b1;

      // R11: grant taken away mid-block
      cur_req = "R11";
      grant_en = 1'b0;
      tick();
      chk("R11", "mem_addr", 32'(mem_addr), 32'h11);
      chk("R11", "mem_valid", 32'(mem_valid), 0);
      tick();
      chk("R11", "mem_addr held", 32'(mem_addr), 32'h11);
      grant_en = 1'b1;

      // R9: completion
      cur_req = "R9";
      wait_irq();
      chk("R9", "irq", 32'(irq), 1);
      chk("R9", "bus_req", 32'(bus_req), 0);
      chk("R5", "final mem_addr", 32'(mem_addr), 32'h14);

      // R10: sticky interrupt
      cur_req = "R10";
      dev_req = 1'b0;
      tick(); tick();
      wr(2'd0, 16'h0100);
      wr(2'd1, 16'd3);
      chk("R10", "irq after addr/count writes", 32'(irq), 1);

      // R7: cycle stealing, memory to device
      cur_req = "R7";
      dev_req = 1'b1;
      wr(2'd2, ctl(1, 1, 0));
      chk("R10", "irq cleared", 32'(irq), 0);
      wait_irq();
      chk("R7", "final mem_addr", 32'(mem_addr), 32'h103);
      chk("R7", "mem_we", 32'(mem_we), 0);

      // R8 and R12: idle-only mode with a device pause
      wr(2'd0, 16'h0200);
      wr(2'd1, 16'd5);
      cur_req = "R8";
      wr(2'd2, ctl(1, 2, 1));
      for (int i = 0; i < 80; i++) begin
         cpu_idle = (i % 3 == 0);
         if (i >= 4 && i < 9) begin
            cur_req = "R12";
            dev_req = 1'b0;
         end else begin
            cur_req = "R8";
            dev_req = 1'b1;
         end
         tick();
         if (irq) break;
      end
      chk("R8", "irq", 32'(irq), 1);
      chk("R12", "final mem_addr", 32'(mem_addr), 32'h205);

      // R9: zero count finishes without the bus
      cur_req = "R9";
      dev_req = 1'b0;
      wr(2'd1, 16'd0);
      wr(2'd2, ctl(1, 0, 0));
      tick();
      chk("R9", "zero count irq", 32'(irq), 1);
      chk("R9", "zero count bus_req", 32'(bus_req), 0);

      // R2: control write without go ignores the device
      cur_req = "R2";
      wr(2'd1, 16'd2);
      wr(2'd2, ctl(0, 1, 1));
      dev_req = 1'b1;
      tick(); tick(); tick();
      chk("R2", "no go bus_req", 32'(bus_req), 0);
      chk("R2", "no go irq", 32'(irq), 0);
      dev_req = 1'b0;
      tick(); tick();

      finish_run();
   end

endmodule